// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the status byte of a serial memory device and decides, cycle by cycle, whether an array write to a given address and a status-register write are permitted. A command decoder elsewhere in the device supplies the decoded latch commands, a status-write request with its data byte, the target array address, the chip-select state and the busy state of the write timer. The block returns the status byte for readback, two permission flags, and a one-cycle start pulse when a status write actually commits.

A status write is accepted into a pending slot while the device is selected. It commits on the cycle where chip select is released, provided permission still holds then. A falling write-protect pin while the device is still selected discards the pending write, but only when the protect-enable bit is set. The protect-enable bit and the two block-protect bits model nonvolatile cells. A hard reset clears them to their factory state. A soft reset, which models a power cycle, keeps them and clears only the volatile state.

Top module: `status_guard`

## Requirements
- R1: The status byte places protect-enable at bit 7, block-protect bits at 3:2, the write-enable latch at bit 1 and the busy flag at bit 0, where the busy flag follows the busy input.
- R2: Status bits 6:4 read as 000 while the busy input is low and as 111 while it is high.
- R3: A committed status write loads only bit 7 and bits 3:2 from its data byte. Data bits 6:4, 1 and 0 have no effect on the status byte.
- R4: Using the top two address bits, block-protect code 00 protects no address, 01 protects addresses whose top bits are 11, 10 protects addresses whose top bit is 1, and 11 protects every address. A protected address never gets array-write permission.
- R5: Array-write permission requires the write-enable latch to be 1, the busy input to be low and the address to be unprotected, including while hardware protection is active.
- R6: While the write-protect pin is low and protect-enable is 1, status-write permission is 0, status-write requests are not accepted, and a pending write does not commit.
- R7: Status-write permission is 1 when the write-enable latch is 1 and busy is low, and either the write-protect pin is high or protect-enable is 0.
- R8: A pending status write commits on the first clock edge where chip select is seen released. The start output pulses high for one cycle in the following cycle, and the new bits show in the status byte from that same cycle.
- R9: A falling write-protect pin while chip select is active and protect-enable is 1 discards a pending status write, so no start pulse follows. After the commit, the write-protect pin has no effect on the written bits.
- R10: The set-latch strobe sets the write-enable latch and the clear-latch strobe clears it. When both strobes arrive together, the clear wins.
- R11: A hard reset clears the whole status byte. A soft reset clears the write-enable latch and any pending write, and keeps protect-enable and the block-protect bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hard reset, factory state |
| softRst | input | 1 | Synchronous soft reset modelling a power cycle |
| csSel | input | 1 | High while the device is selected |
| wpN | input | 1 | Write-protect pin level, low protects |
| setWel | input | 1 | Decoded strobe that sets the write-enable latch |
| clrWel | input | 1 | Decoded strobe that clears the write-enable latch |
| statWrReq | input | 1 | Strobe that offers a status-write data byte |
| statWrData | input | 8 | Status-write data byte |
| addr | input | ADDR_W | Target array address |
| busy | input | 1 | Write timer busy |
| statByte | output | 8 | Status byte for readback |
| arrWrOk | output | 1 | Array write to addr permitted |
| statWrOk | output | 1 | Status write permitted |
| statWrStart | output | 1 | One-cycle pulse when a status write commits |

## Verification
A wrong protection code or a dropped write-enable latch shows in the same cycle on the permission outputs for a matching address. The nonvolatile bits show on the status byte one cycle after the wrong commit. A pending write that is lost or that survives a cancel shows only at the next chip-select release, as a missing or extra start pulse and as unchanged or changed status bits one cycle later. For this reason the stimulus often keeps the device selected across write-protect edges and across several requests before releasing it.

// File: rtl/status_guard_pkg.sv
package status_guard_pkg;

  typedef struct packed {
    logic loadPend;
    logic dropPend;
    logic commitPend;
    logic welSet;
    logic welClr;
    logic softClr;
  } guardStrobe_t;

  localparam int RSV_W = 3;

  function automatic logic inProtRange(input logic [1:0] bpCode, input logic [1:0] topBits);
    logic hit;
    case (bpCode)
      2'b00:   hit = 1'b0;
      2'b01:   hit = &topBits;
      2'b10:   hit = topBits[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/status_guard_ctrl.sv
module status_guard_ctrl
  import status_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         softRst,
  input  logic         csSel,
  input  logic         wpN,
  input  logic         setWel,
  input  logic         clrWel,
  input  logic         statWrReq,
  input  logic         busy,
  input  logic         wpen,
  input  logic         wel,
  input  logic         pendValid,
  output guardStrobe_t stb,
  output logic         statWrOk,
  output logic         statWrStart
);

  logic prevCs;
  logic prevWpN;
  logic startQ;
  logic csFall;
  logic wpFall;
  logic hwLock;

  assign csFall   = prevCs & ~csSel;
  assign wpFall   = prevWpN & ~wpN;
  assign hwLock   = ~wpN & wpen;
  assign statWrOk = wel & ~busy & ~hwLock;

  always_comb begin
    stb            = '0;
    stb.softClr    = softRst;
    stb.welClr     = softRst | clrWel;
    stb.welSet     = ~softRst & setWel & ~clrWel;
    stb.commitPend = ~softRst & pendValid & csFall & statWrOk;
    stb.dropPend   = ~softRst & pendValid & (csFall | (csSel & wpFall & wpen));
    stb.loadPend   = ~softRst & ~stb.dropPend & statWrReq & csSel & statWrOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs  <= 1'b0;
      prevWpN <= 1'b1;
      startQ  <= 1'b0;
    end else if (softRst) begin
      prevCs  <= 1'b0;
      prevWpN <= 1'b1;
      startQ  <= 1'b0;
    end else begin
      prevCs  <= csSel;
      prevWpN <= wpN;
      startQ  <= stb.commitPend;
    end
  end

  assign statWrStart = startQ;

  assert_commit_needs_pend_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.commitPend |-> (pendValid && !csSel));

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    statWrStart |=> !statWrStart);

endmodule

// File: rtl/status_guard_dp.sv
module status_guard_dp
  import status_guard_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobe_t      stb,
  input  logic [7:0]        statWrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              wpen,
  output logic              wel,
  output logic              pendValid,
  output logic [7:0]        statByte,
  output logic              arrWrOk
);

  localparam int TOP_LO = ADDR_W - 2;

  logic [1:0] bp;
  logic [7:0] pendData;
  logic [1:0] topBits;
  logic [RSV_W-1:0] rsvBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpen      <= 1'b0;
      bp        <= 2'b00;
      wel       <= 1'b0;
      pendValid <= 1'b0;
      pendData  <= 8'h00;
    end else begin
      if (stb.commitPend) begin
        wpen <= pendData[7];
        bp   <= pendData[3:2];
      end
      if (stb.dropPend || stb.softClr) begin
        pendValid <= 1'b0;
      end else if (stb.loadPend) begin
        pendValid <= 1'b1;
        pendData  <= statWrData;
      end
      if (stb.welClr) begin
        wel <= 1'b0;
      end else if (stb.welSet) begin
        wel <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < RSV_W; i++) begin : g_rsv
    assign rsvBits[i] = busy;
  end

  assign topBits  = addr[TOP_LO +: 2];
  assign statByte = {wpen, rsvBits, bp, wel, busy};
  assign arrWrOk  = wel & ~busy & ~inProtRange(bp, topBits);

  assert_nv_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commitPend |=> $stable({wpen, bp}));

  assert_soft_clears_wel_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.softClr |=> (!wel && !pendValid));

endmodule

// File: rtl/status_guard.sv
module status_guard
  import status_guard_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              csSel,
  input  logic              wpN,
  input  logic              setWel,
  input  logic              clrWel,
  input  logic              statWrReq,
  input  logic [7:0]        statWrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic [7:0]        statByte,
  output logic              arrWrOk,
  output logic              statWrOk,
  output logic              statWrStart
);

  guardStrobe_t stb;
  logic wpen;
  logic wel;
  logic pendValid;

  status_guard_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .csSel(csSel), .wpN(wpN),
    .setWel(setWel), .clrWel(clrWel), .statWrReq(statWrReq), .busy(busy),
    .wpen(wpen), .wel(wel), .pendValid(pendValid), .stb(stb),
    .statWrOk(statWrOk), .statWrStart(statWrStart)
  );

  status_guard_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .statWrData(statWrData), .addr(addr),
    .busy(busy), .wpen(wpen), .wel(wel), .pendValid(pendValid),
    .statByte(statByte), .arrWrOk(arrWrOk)
  );

  assert_full_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statByte[3:2] == 2'b11) |-> !arrWrOk);

endmodule

// File: tb/test_status_guard.sv
`timescale 1ns/1ps
module test_status_guard;
  localparam int AW = 14;
  localparam int SIZE = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0, csSel = 1'b0, wpN = 1'b1, setWel = 1'b0, clrWel = 1'b0;
  logic statWrReq = 1'b0, busy = 1'b0;
  logic [7:0] statWrData = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0] statByte;
  logic arrWrOk, statWrOk, statWrStart;

  int checks = 0;
  int errors = 0;

  // reference state
  bit mWpen, mWel, mPend, mPrevCs, mPrevWpN = 1, mStart;
  int mBp;
  int mData;

  always #2.5 clk = ~clk;

  status_guard #(.ADDR_W(AW)) i_status_guard (
    .clk(clk), .rstN(rstN), .softRst(softRst), .csSel(csSel), .wpN(wpN),
    .setWel(setWel), .clrWel(clrWel), .statWrReq(statWrReq), .statWrData(statWrData),
    .addr(addr), .busy(busy), .statByte(statByte), .arrWrOk(arrWrOk),
    .statWrOk(statWrOk), .statWrStart(statWrStart)
  );

  function automatic bit refStatOk();
    return mWel && !busy && !(!wpN && mWpen);
  endfunction

  function automatic bit refProt(int a);
    if (mBp == 3) return 1;
    if (mBp == 2) return a >= SIZE / 2;
    if (mBp == 1) return a >= (SIZE / 4) * 3;
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWpen = 0; mBp = 0; mWel = 0; mPend = 0; mData = 0;
      mPrevCs = 0; mPrevWpN = 1; mStart = 0;
    end else if (softRst) begin
      mWel = 0; mPend = 0; mPrevCs = 0; mPrevWpN = 1; mStart = 0;
    end else begin
      bit ok, csFall, wpFall;
      ok = refStatOk();
      csFall = mPrevCs && !csSel;
      wpFall = mPrevWpN && !wpN;
      mStart = 0;
      if (mPend && csFall) begin
        if (ok) begin
          mWpen = mData[7];
          mBp = (mData >> 2) & 3;
          mStart = 1;
        end
        mPend = 0;
      end else if (mPend && csSel && wpFall && mWpen) begin
        mPend = 0;
      end else if (statWrReq && csSel && ok) begin
        mPend = 1;
        mData = statWrData;
      end
      if (clrWel) mWel = 0;
      else if (setWel) mWel = 1;
      mPrevCs = csSel;
      mPrevWpN = wpN;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int expByte;
    expByte = (mWpen << 7) | (busy ? 8'h70 : 0) | (mBp << 2) | (mWel << 1) | busy;
    check("R1 R2 R3 R9 R10 R11 statByte", statByte, expByte);
    check("R4 R5 arrWrOk", arrWrOk, mWel && !busy && !refProt(addr));
    check("R6 R7 statWrOk", statWrOk, refStatOk());
    check("R8 R9 statWrStart", statWrStart, mStart);
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic pulse(input logic s, input logic c, input logic r, input logic [7:0] d);
    setWel = s; clrWel = c; statWrReq = r; statWrData = d;
    tick();
    setWel = 0; clrWel = 0; statWrReq = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    check("R11 reset byte", statByte, 8'h00);
    // R10: set, then simultaneous set and clear
    pulse(1, 0, 0, 0);
    check("R10 wel set", statByte, 8'h02);
    pulse(1, 1, 0, 0);
    check("R10 clear wins", statByte, 8'h00);
    // R3 R8: full write with junk in ignored bits
    pulse(1, 0, 0, 0);
    csSel = 1;
    pulse(0, 0, 1, 8'hFF);
    csSel = 0;
    tick();
    check("R8 start pulse", statWrStart, 1);
    check("R3 committed bits", statByte, 8'h8E);
    tick();
    check("R8 single pulse", statWrStart, 0);
    // R4: whole array locked
    addr = '0;
    tick();
    check("R4 bp11 locks low address", arrWrOk, 0);
    // R6: hardware lock
    wpN = 0;
    tick();
    check("R6 status write refused", statWrOk, 0);
    // R2: busy reserved bits
    busy = 1;
    tick();
    check("R2 busy byte", statByte, 8'hFF);
    busy = 0; wpN = 1;
    // R9: cancel by falling WP while selected
    csSel = 1;
    pulse(0, 0, 1, 8'h84);
    wpN = 0;
    tick();
    wpN = 1;
    tick();
    csSel = 0;
    tick();
    check("R9 cancelled no start", statWrStart, 0);
    tick();
    check("R9 bits unchanged", statByte[3:2], 2'b11);
    // R11: soft reset keeps nonvolatile bits
    softRst = 1;
    tick();
    softRst = 0;
    tick();
    check("R11 soft reset keeps nv", statByte, 8'h8C);
    // R4 R5 R7: unlock via WPEN=0 and walk codes
    for (int code = 0; code < 4; code++) begin
      pulse(1, 0, 0, 0);
      csSel = 1;
      pulse(0, 0, 1, 8'(code << 2));
      csSel = 0;
      tick();
      pulse(1, 0, 0, 0);
      for (int q = 0; q < 8; q++) begin
        addr = AW'(q * (SIZE / 8));
        tick();
      end
    end
    // random phase
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 15) csSel = ~csSel;
      if ($urandom_range(0, 99) < 10) wpN = ~wpN;
      busy = ($urandom_range(0, 99) < 15);
      setWel = ($urandom_range(0, 99) < 25);
      clrWel = ($urandom_range(0, 99) < 8);
      statWrReq = ($urandom_range(0, 99) < 25);
      statWrData = 8'($urandom);
      addr = AW'($urandom);
      softRst = ($urandom_range(0, 999) < 5);
      tick();
    end
    setWel = 0; clrWel = 0; statWrReq = 0; softRst = 0; busy = 0;
    tick();
    @(negedge clk);
    rstN = 0;
    #1;
    check("R11 hard reset byte", statByte, 8'h00);
    @(negedge clk);
    rstN = 1;
    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule